// File: doc/BRIEF.md
# Deferred Floating-Point Error Controller

This block holds a floating-point error that was found in one instruction and reports it only when a later instruction needs it. The floating-point unit sends a completion report with three parts: a vector of exception flags, a vector of mask bits, and the address of the instruction that produced them. A flag that is raised and not masked makes an error pending. The block stores the address of that faulting instruction in a pointer register of its own, so the handler can read it later.

The issue side presents one classified instruction per cycle, each with its own address. If a waiting floating-point instruction or an explicit WAIT tries to issue while an error is pending, the block stalls it in that cycle. One cycle later the block raises a one-cycle trap pulse and records the address of the stalled instruction as the return address. All other classes issue without any check: non-floating-point, the non-waiting control group, and the extended state save and restore pair. The clear and initialise class also issues without a check, and it empties the pending bit and the sticky flags. The trap never carries an error code.

Top module: `fpx_defer_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the block sets `pending_o`, `status_o`, `flt_ptr_o`, `ret_ptr_o` and `trap_o` to zero.
- R2: A completion with `cmp_valid` high and at least one bit set in `cmp_flags & ~cmp_mask` sets `pending_o` on the next cycle. In the same update, `flt_ptr_o` takes `cmp_addr`.
- R3: A completion whose raised flags are all masked ORs `cmp_flags` into the sticky `status_o`. It leaves `pending_o` and `flt_ptr_o` unchanged.
- R4: The block stalls an issue of class 1 (waiting FP) or class 2 (WAIT) when `pending_o` is high. In that case `stall_o` is high in the same cycle. On the next cycle `trap_o` is high for exactly one cycle, and `ret_ptr_o` holds the `iss_addr` of the stalled instruction.
- R5: An issue of class 0 (non-FP), 3 (non-waiting control), 5 (state save/restore), or of the unused codes 6 and 7, never raises `stall_o` or `trap_o`. This holds even while an error is pending, and the pending bit is left set.
- R6: An issue of class 4 (clear/initialise) clears `pending_o` and `status_o` on the next cycle and keeps `flt_ptr_o`. If a completion arrives in the same cycle, its flags and any unmasked error take effect after the clear.
- R7: A new unmasked error that arrives while one is already pending keeps `pending_o` high and overwrites `flt_ptr_o` with the newer address.
- R8: A trap does not clear the pending bit. A waiting instruction that retries before a clear traps again.
- R9: `err_code_valid_o` is always low and `err_code_o` is always zero.
- R10: A class 1 or class 2 issue with no error pending proceeds without a stall or a trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_valid | input | 1 | Completion report present |
| cmp_flags | input | NFLAG | Exception flags raised by the completed instruction |
| cmp_mask | input | NFLAG | Mask bits, 1 = flag masked |
| cmp_addr | input | AW | Address of the completed instruction |
| iss_valid | input | 1 | Instruction attempting to issue |
| iss_class | input | 3 | Instruction class (0 to 5 as in the requirements) |
| iss_addr | input | AW | Address of the issuing instruction |
| stall_o | output | 1 | Issue held in this cycle |
| trap_o | output | 1 | One-cycle error trap pulse |
| ret_ptr_o | output | AW | Address of the instruction stalled by the last trap |
| flt_ptr_o | output | AW | Address of the latest unmasked faulting instruction |
| status_o | output | NFLAG | Sticky exception flags |
| pending_o | output | 1 | Unmasked error waiting to be reported |
| err_code_valid_o | output | 1 | Error code present (always low) |
| err_code_o | output | ECW | Error code (always zero) |

## Verification
The hardest case to reach is a clear-class issue and an unmasked completion landing in the same cycle. The stimulus drives both on one falling edge and then checks that the new error survives, both in the flags and as a later trap. The second hard case is a run of retried waiting instructions against one pending error, which must each trap with the return address of that attempt. The bench sweeps every flag and mask combination of a four-flag configuration and probes each one with a waiting issue. It also sweeps all eight class codes while an error is pending.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  typedef enum logic [2:0] {
    CLS_PLAIN  = 3'd0,
    CLS_FPWAIT = 3'd1,
    CLS_WAIT   = 3'd2,
    CLS_CTRL   = 3'd3,
    CLS_CLEAR  = 3'd4,
    CLS_XSTATE = 3'd5
  } fpx_cls_e;

  // classes that must look at the pending error before issuing
  function automatic logic cls_checks(input logic [2:0] c);
    return (c == CLS_FPWAIT) || (c == CLS_WAIT);
  endfunction

  function automatic logic cls_clears(input logic [2:0] c);
    return c == CLS_CLEAR;
  endfunction
endpackage

// File: rtl/fpx_err_track.sv
module fpx_err_track #(
  parameter int NFLAG = 6,
  parameter int AW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_valid,
  input  logic [NFLAG-1:0] cmp_flags,
  input  logic [NFLAG-1:0] cmp_mask,
  input  logic [AW-1:0]    cmp_addr,
  input  logic             clr_req,
  output logic             pending_q,
  output logic [NFLAG-1:0] status_q,
  output logic [AW-1:0]    flt_ptr_q
);
  logic             unmasked_hit;
  logic [NFLAG-1:0] raised;

  assign raised       = cmp_valid ? cmp_flags : '0;
  assign unmasked_hit = cmp_valid && (|(cmp_flags & ~cmp_mask));

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q <= 1'b0;
      status_q  <= '0;
      flt_ptr_q <= '0;
    end else begin
      // clear first, then the incoming report is merged on top
      status_q <= (clr_req ? '0 : status_q) | raised;
      if (unmasked_hit) begin
        pending_q <= 1'b1;
        flt_ptr_q <= cmp_addr;
      end else if (clr_req) begin
        pending_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fpx_issue_gate.sv
module fpx_issue_gate #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          iss_valid,
  input  logic [2:0]    iss_class,
  input  logic [AW-1:0] iss_addr,
  input  logic          pending,
  output logic          stall,
  output logic          clr_req,
  output logic          trap_q,
  output logic [AW-1:0] ret_ptr_q
);
  import fpx_pkg::*;

  assign stall   = iss_valid && cls_checks(iss_class) && pending;
  assign clr_req = iss_valid && cls_clears(iss_class);

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_q    <= 1'b0;
      ret_ptr_q <= '0;
    end else begin
      trap_q <= stall;
      if (stall) ret_ptr_q <= iss_addr;
    end
  end
endmodule

// File: rtl/fpx_defer_ctrl.sv
module fpx_defer_ctrl #(
  parameter int NFLAG = 6,
  parameter int AW    = 32,
  parameter int ECW   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_valid,
  input  logic [NFLAG-1:0] cmp_flags,
  input  logic [NFLAG-1:0] cmp_mask,
  input  logic [AW-1:0]    cmp_addr,
  input  logic             iss_valid,
  input  logic [2:0]       iss_class,
  input  logic [AW-1:0]    iss_addr,
  output logic             stall_o,
  output logic             trap_o,
  output logic [AW-1:0]    ret_ptr_o,
  output logic [AW-1:0]    flt_ptr_o,
  output logic [NFLAG-1:0] status_o,
  output logic             pending_o,
  output logic             err_code_valid_o,
  output logic [ECW-1:0]   err_code_o
);
  logic clr_req;

  fpx_err_track #(.NFLAG(NFLAG), .AW(AW)) u_track (
    .clk       (clk),
    .rst       (rst),
    .cmp_valid (cmp_valid),
    .cmp_flags (cmp_flags),
    .cmp_mask  (cmp_mask),
    .cmp_addr  (cmp_addr),
    .clr_req   (clr_req),
    .pending_q (pending_o),
    .status_q  (status_o),
    .flt_ptr_q (flt_ptr_o)
  );

  fpx_issue_gate #(.AW(AW)) u_gate (
    .clk       (clk),
    .rst       (rst),
    .iss_valid (iss_valid),
    .iss_class (iss_class),
    .iss_addr  (iss_addr),
    .pending   (pending_o),
    .stall     (stall_o),
    .clr_req   (clr_req),
    .trap_q    (trap_o),
    .ret_ptr_q (ret_ptr_o)
  );

  // this trap class reports no error code of its own
  assign err_code_valid_o = 1'b0;
  assign err_code_o       = '0;
endmodule

// File: rtl/fpx_defer_chk.sv
module fpx_defer_chk #(
  parameter int NFLAG = 6,
  parameter int AW    = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             cmp_valid,
  input logic [NFLAG-1:0] cmp_flags,
  input logic [NFLAG-1:0] cmp_mask,
  input logic             iss_valid,
  input logic [2:0]       iss_class,
  input logic [AW-1:0]    iss_addr,
  input logic             stall_o,
  input logic             trap_o,
  input logic [AW-1:0]    ret_ptr_o,
  input logic [AW-1:0]    flt_ptr_o,
  input logic             pending_o
);
  logic unm;
  assign unm = cmp_valid && (|(cmp_flags & ~cmp_mask));

  p_pend_set_r2: assert property (@(posedge clk) disable iff (rst)
    unm |=> pending_o);

  p_ptr_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !unm |=> $stable(flt_ptr_o));

  p_stall_cause_r4: assert property (@(posedge clk) disable iff (rst)
    stall_o |-> (pending_o && iss_valid && (iss_class == 3'd1 || iss_class == 3'd2)));

  p_trap_after_stall_r4: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> ($past(stall_o) && ret_ptr_o == $past(iss_addr)));

  p_no_check_r5: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_class != 3'd1 && iss_class != 3'd2) |-> !stall_o);

  p_trap_keeps_pend_r8: assert property (@(posedge clk) disable iff (rst)
    (stall_o && !cmp_valid) |=> pending_o);
endmodule

bind fpx_defer_ctrl fpx_defer_chk #(.NFLAG(NFLAG), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmp_valid (cmp_valid),
  .cmp_flags (cmp_flags),
  .cmp_mask  (cmp_mask),
  .iss_valid (iss_valid),
  .iss_class (iss_class),
  .iss_addr  (iss_addr),
  .stall_o   (stall_o),
  .trap_o    (trap_o),
  .ret_ptr_o (ret_ptr_o),
  .flt_ptr_o (flt_ptr_o),
  .pending_o (pending_o)
);

// File: tb/tb_fpx_defer_ctrl.sv
module tb_fpx_defer_ctrl;
  localparam int NFLAG = 4;
  localparam int AW    = 8;
  localparam int ECW   = 16;

  logic             clk = 1'b0;
  logic             rst;
  logic             cmp_valid;
  logic [NFLAG-1:0] cmp_flags, cmp_mask;
  logic [AW-1:0]    cmp_addr;
  logic             iss_valid;
  logic [2:0]       iss_class;
  logic [AW-1:0]    iss_addr;
  logic             stall_o, trap_o, pending_o, err_code_valid_o;
  logic [AW-1:0]    ret_ptr_o, flt_ptr_o;
  logic [NFLAG-1:0] status_o;
  logic [ECW-1:0]   err_code_o;

  int total = 0;
  int bad   = 0;

  // reference state built from the requirements
  logic             m_pend;
  logic [NFLAG-1:0] m_stat;
  logic [AW-1:0]    m_fptr, m_rptr;

  always #2 clk = ~clk;

  fpx_defer_ctrl #(.NFLAG(NFLAG), .AW(AW), .ECW(ECW)) dut (.*);

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    check({req, " pending"}, pending_o, m_pend);
    check({req, " status"},  status_o,  m_stat);
    check({req, " flt_ptr"}, flt_ptr_o, m_fptr);
    check("R9 code_valid", err_code_valid_o, 0);
    check("R9 code", err_code_o, 0);
  endtask

  task automatic complete(input logic [NFLAG-1:0] f, input logic [NFLAG-1:0] m,
                          input logic [AW-1:0] a);
    @(negedge clk);
    cmp_valid = 1'b1; cmp_flags = f; cmp_mask = m; cmp_addr = a;
    @(negedge clk);
    cmp_valid = 1'b0;
    m_stat = m_stat | f;
    if ((f & ~m) != 0) begin m_pend = 1'b1; m_fptr = a; end
  endtask

  // issue one instruction, check stall in its cycle and the trap pulse after
  task automatic issue(input logic [2:0] c, input logic [AW-1:0] a, input string req);
    logic exp_stall;
    @(negedge clk);
    iss_valid = 1'b1; iss_class = c; iss_addr = a;
    exp_stall = m_pend && (c == 3'd1 || c == 3'd2);
    #1 check({req, " stall"}, stall_o, exp_stall);
    @(negedge clk);
    iss_valid = 1'b0;
    if (c == 3'd4) begin m_pend = 1'b0; m_stat = '0; end
    if (exp_stall) m_rptr = a;
    check({req, " trap"}, trap_o, exp_stall);
    check({req, " ret_ptr"}, ret_ptr_o, m_rptr);
    check_state(req);
    @(negedge clk);
    check({req, " trap pulse width"}, trap_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; cmp_valid = 0; cmp_flags = 0; cmp_mask = 0; cmp_addr = 0;
    iss_valid = 0; iss_class = 0; iss_addr = 0;
    m_pend = 0; m_stat = 0; m_fptr = 0; m_rptr = 0;
    repeat (3) @(negedge clk);
    check_state("R1 reset");
    check("R1 reset trap", trap_o, 0);
    check("R1 reset ret_ptr", ret_ptr_o, 0);
    rst = 1'b0;

    // R10: waiting issue with nothing pending
    issue(3'd1, 8'h11, "R10 fpwait clean");
    issue(3'd2, 8'h12, "R10 wait clean");

    // R2 R3 R4: all flag/mask combinations, each probed by a waiting issue
    for (int f = 0; f < 16; f++) begin
      for (int m = 0; m < 16; m++) begin
        issue(3'd4, 8'hF0, "R6 clear");
        complete(f[NFLAG-1:0], m[NFLAG-1:0], 8'(f * 16 + m));
        check_state(((f & ~m) != 0) ? "R2 unmasked" : "R3 masked");
        issue(((f + m) % 2 == 0) ? 3'd1 : 3'd2, 8'(255 - f - m), "R4 probe");
      end
    end

    // R5: every class with an error pending
    issue(3'd4, 8'h00, "R6 clear");
    complete(4'b0001, 4'b0000, 8'hA5);
    for (int c = 0; c < 8; c++) begin
      if (c != 4) issue(3'(c), 8'(8'h40 + c), (c == 1 || c == 2) ? "R4 class" : "R5 class");
    end

    // R8: retries keep trapping
    issue(3'd1, 8'h51, "R8 retry1");
    issue(3'd2, 8'h52, "R8 retry2");
    issue(3'd1, 8'h53, "R8 retry3");

    // R7: newer error overwrites pointer
    complete(4'b0010, 4'b0000, 8'h3C);
    check_state("R7 overwrite");

    // R6: clear and unmasked completion in the same cycle
    @(negedge clk);
    iss_valid = 1; iss_class = 3'd4; iss_addr = 8'h77;
    cmp_valid = 1; cmp_flags = 4'b1000; cmp_mask = 4'b0000; cmp_addr = 8'h9E;
    #1 check("R6 clear no stall", stall_o, 0);
    @(negedge clk);
    iss_valid = 0; cmp_valid = 0;
    m_stat = 4'b1000; m_pend = 1; m_fptr = 8'h9E;
    check_state("R6 same cycle");
    issue(3'd2, 8'h61, "R6 survives");

    // R6: plain clear keeps faulting pointer
    issue(3'd4, 8'h62, "R6 clear keep ptr");
    issue(3'd1, 8'h63, "R6 after clear");

    // R1: reset mid-run
    complete(4'b0100, 4'b0000, 8'hCC);
    issue(3'd1, 8'h64, "R4 before reset");
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    m_pend = 0; m_stat = 0; m_fptr = 0; m_rptr = 0;
    check_state("R1 mid reset");
    check("R1 mid reset ret_ptr", ret_ptr_o, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule